// File: doc/BRIEF.md
# Performance-Alert Event Branch Controller

This block turns an alert from a performance monitor into a branch into a user-level event handler. It holds a small set of monitor control bits, a set of branch status bits, a return-address register and a handler-address register. Software loads all four through one write port, and the block drives their current contents on its outputs.

An alert is handled in two phases. In the first phase, which takes effect at the clock edge that samples the alert, the block freezes the counters and raises the alert-occurred flag if software armed those actions. It also latches a pending interrupt. In the second phase the pending interrupt is taken at the first edge on which the core is in user state. Taking it always clears the pending flag. If both branch enables are set, taking it also saves the program counter, updates the status bits and emits a one-cycle redirect to the handler. If either enable is clear, the event is dropped and nothing else changes.

The counters, the overflow detection that produces the alert, and the return-from-handler instruction are outside this block. A single-cycle alert pulse stands in for the alert source.

Top module: `ebb_alert_ctrl`

## Requirements
- R1: While monitor-control bit 0 (monitor enable) is 0, an alert pulse changes no control bit and sets no pending interrupt.
- R2: When an alert is accepted and monitor-control bit 1 (freeze-on-alert arm) is 1, bit 1 clears and bit 2 (freeze counters) sets.
- R3: When an alert is accepted and monitor-control bit 3 (alert enable) is 1, bit 3 clears and bit 4 (alert occurred) sets.
- R4: An accepted alert sets the pending flag at the same edge that updates the control bits.
- R5: A pending interrupt is taken only at an edge where user_mode_i is 1. Otherwise it stays pending and no redirect is issued.
- R6: Taking the pending interrupt clears the pending flag, unless an accepted alert arrives at the same edge, in which case the flag stays set.
- R7: When the interrupt is taken with status bit 0 (global enable) and status bit 1 (monitor event enable) both 1, the block does four things at that edge: it clears bit 0, sets status bit 2 (monitor event occurred), loads pc_i into the return-address register, and issues a redirect to the handler address.
- R8: When the interrupt is taken with status bit 0 or bit 1 clear, no redirect is issued, and the status bits and the return address keep their values.
- R9: redir_valid_o is high for exactly one cycle per redirect. The low two bits of redir_target_o are zero, and the other bits match the handler address.
- R10: The write port selects registers with wr_sel_i: 0 = monitor control, 1 = status, 2 = return address, 3 = handler address. When an alert or a take updates a bit in the same cycle as a write to that register, the hardware update of that bit wins. All other bits take the written value.
- R11: Reset, synchronous and active low, clears all control bits, all status bits, both address registers, the pending flag and the redirect output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alert_i | input | 1 | Single-cycle performance monitor alert |
| pc_i | input | 64 | Program counter of the current instruction |
| user_mode_i | input | 1 | Core is in user (problem) state |
| wr_en_i | input | 1 | Software register write strobe |
| wr_sel_i | input | 2 | Register select: 0 ctrl, 1 status, 2 return, 3 handler |
| wr_data_i | input | 64 | Write data, low bits used for ctrl/status |
| mon_ctrl_o | output | 5 | Monitor control bits |
| br_status_o | output | 3 | Branch status bits |
| ret_addr_o | output | 64 | Return-address register |
| hdl_addr_o | output | 64 | Handler-address register |
| pend_o | output | 1 | Pending monitor interrupt |
| redir_valid_o | output | 1 | Redirect pulse |
| redir_target_o | output | 64 | Redirect target, word aligned |

## Verification
The hardest cases to reach are the collisions, where hardware and software update the same register at one edge. One is an alert landing while software rewrites the control bits. The other is an interrupt being taken while software rewrites the status bits. The bench lines these up by raising the write strobe and the alert, or the user-state flag over an already pending interrupt, in the same cycle. It then reads back the merged register value. A vector table runs every combination of enable and arm bits through one alert with the core held in supervisor state, so the pending flag can be checked without it being taken.

// File: rtl/ebb_alert_pkg.sv
// Package: shared register layouts and write-select codes for the
// event branch controller. Bit order of the packed structs is the
// software-visible layout (first member is the MSB).
package ebb_alert_pkg;

    typedef enum logic [1:0] {
        SEL_MON  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_RET  = 2'd2,
        SEL_HDL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic alrt_seen;  // bit 4
        logic alrt_en;    // bit 3
        logic frz;        // bit 2
        logic frz_arm;    // bit 1
        logic en;         // bit 0
    } mon_t;

    typedef struct packed {
        logic pm_hit;     // bit 2
        logic pm_en;      // bit 1
        logic glb_en;     // bit 0
    } stat_t;

    localparam int MON_W  = $bits(mon_t);
    localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/ebb_mon_regs.sv
// Module: monitor control register. Handles the first phase of an alert:
// freeze arm -> freeze, alert enable -> alert seen. Assumes alert_i is
// synchronous to clk. Alert updates override a software write of the same
// bits in the same cycle.
module ebb_mon_regs
    import ebb_alert_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic alert_i,
    input  logic wr_en_i,
    input  mon_t wr_data_i,
    output mon_t mon_o,
    output logic accept_o
);

    mon_t mon_q;
    mon_t mon_d;

    assign accept_o = alert_i && mon_q.en;
    assign mon_o    = mon_q;

    // Merge software write with the alert-driven bit updates.
    always_comb begin
        mon_d = wr_en_i ? wr_data_i : mon_q;
        if (accept_o && mon_q.frz_arm) begin
            mon_d.frz_arm = 1'b0;
            mon_d.frz     = 1'b1;
        end
        if (accept_o && mon_q.alrt_en) begin
            mon_d.alrt_en   = 1'b0;
            mon_d.alrt_seen = 1'b1;
        end
    end

    // Register the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    AST_ALERT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_i && !mon_q.en && !wr_en_i) |=> $stable(mon_q)); // R1
    AST_FREEZE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && mon_q.frz_arm) |=> (mon_q.frz && !mon_q.frz_arm)); // R2
    AST_ALERT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && mon_q.alrt_en) |=> (mon_q.alrt_seen && !mon_q.alrt_en)); // R3

endmodule

// File: rtl/ebb_pend.sv
// Module: pending interrupt latch. Set by an accepted alert, taken only
// in user state. A fresh alert at the take edge keeps the flag set.
module ebb_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic user_i,
    output logic pend_o,
    output logic take_o
);

    logic pend_q;

    assign take_o = pend_q && user_i;
    assign pend_o = pend_q;

    // Set on accept, clear on take.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= accept_i || (pend_q && !take_o);
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> pend_q); // R4
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !user_i) |=> pend_q); // R5
    AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && user_i && !accept_i) |=> !pend_q); // R6

endmodule

// File: rtl/ebb_branch_unit.sv
// Module: branch status, return and handler address registers, and the
// redirect pulse. Second phase of an alert: on a take with both enables
// set, save the PC and redirect to the word-aligned handler address.
// Take updates override software writes of the same bits.
module ebb_branch_unit
    import ebb_alert_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              stat_wr_i,
    input  logic              ret_wr_i,
    input  logic              hdl_wr_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output stat_t             stat_o,
    output logic [ADDR_W-1:0] ret_o,
    output logic [ADDR_W-1:0] hdl_o,
    output logic              redir_valid_o,
    output logic [ADDR_W-1:0] redir_target_o
);

    stat_t             stat_q, stat_d;
    logic [ADDR_W-1:0] ret_q, hdl_q, tgt_q;
    logic              rv_q;
    logic              fire;

    assign fire = take_i && stat_q.glb_en && stat_q.pm_en;

    // Merge software status write with the take-driven updates.
    always_comb begin
        stat_d = stat_wr_i ? stat_t'(wr_data_i[STAT_W-1:0]) : stat_q;
        if (fire) begin
            stat_d.glb_en = 1'b0;
            stat_d.pm_hit = 1'b1;
        end
    end

    // Status, address registers and the redirect pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ret_q  <= '0;
            hdl_q  <= '0;
            tgt_q  <= '0;
            rv_q   <= 1'b0;
        end else begin
            stat_q <= stat_d;
            if (fire)          ret_q <= pc_i;
            else if (ret_wr_i) ret_q <= wr_data_i;
            if (hdl_wr_i)      hdl_q <= wr_data_i;
            rv_q <= fire;
            if (fire) tgt_q <= {hdl_q[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        end
    end

    assign stat_o         = stat_q;
    assign ret_o          = ret_q;
    assign hdl_o          = hdl_q;
    assign redir_valid_o  = rv_q;
    assign redir_target_o = tgt_q;

    AST_REDIR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rv_q && !stat_q.glb_en && stat_q.pm_hit && ret_q == $past(pc_i))); // R7
    AST_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !(stat_q.glb_en && stat_q.pm_en) && !stat_wr_i && !ret_wr_i)
        |=> (!rv_q && $stable(stat_q) && $stable(ret_q))); // R8
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rv_q |=> !rv_q); // R9
    AST_TGT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (tgt_q[ADDR_W-1:ALIGN_BITS] == $past(hdl_q[ADDR_W-1:ALIGN_BITS]))); // R9

endmodule

// File: rtl/ebb_alert_ctrl.sv
// Module: top of the event branch controller. Decodes the software write
// port and connects the monitor register, the pending latch and the
// branch unit. Assumes all inputs are synchronous to clk.
module ebb_alert_ctrl
    import ebb_alert_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alert_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              user_mode_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    output logic [MON_W-1:0]  mon_ctrl_o,
    output logic [STAT_W-1:0] br_status_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic [ADDR_W-1:0] hdl_addr_o,
    output logic              pend_o,
    output logic              redir_valid_o,
    output logic [ADDR_W-1:0] redir_target_o
);

    localparam int NUM_REGS = 4;

    logic [NUM_REGS-1:0] wr_hit;
    mon_t                mon;
    stat_t               stat;
    logic                accept;
    logic                take;

    // One write strobe per register select code.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_wdec
        assign wr_hit[g] = wr_en_i && (wr_sel_i == 2'(g));
    end

    ebb_mon_regs u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .alert_i   (alert_i),
        .wr_en_i   (wr_hit[SEL_MON]),
        .wr_data_i (mon_t'(wr_data_i[MON_W-1:0])),
        .mon_o     (mon),
        .accept_o  (accept)
    );

    ebb_pend u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .user_i   (user_mode_i),
        .pend_o   (pend_o),
        .take_o   (take)
    );

    ebb_branch_unit #(
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_br (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_i         (take),
        .pc_i           (pc_i),
        .stat_wr_i      (wr_hit[SEL_STAT]),
        .ret_wr_i       (wr_hit[SEL_RET]),
        .hdl_wr_i       (wr_hit[SEL_HDL]),
        .wr_data_i      (wr_data_i),
        .stat_o         (stat),
        .ret_o          (ret_addr_o),
        .hdl_o          (hdl_addr_o),
        .redir_valid_o  (redir_valid_o),
        .redir_target_o (redir_target_o)
    );

    assign mon_ctrl_o  = mon;
    assign br_status_o = stat;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (pend_o == 1'b0 && redir_valid_o == 1'b0 && mon_ctrl_o == '0)); // R11

endmodule

// File: tb/ebb_alert_ctrl_tb.sv
// Bench: vector table of control-bit combinations through one alert,
// then directed tests for taking, dropping, collisions and reset.
module ebb_alert_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        alert_i;
    logic [63:0] pc_i;
    logic        user_mode_i;
    logic        wr_en_i;
    logic [1:0]  wr_sel_i;
    logic [63:0] wr_data_i;
    logic [4:0]  mon_ctrl_o;
    logic [2:0]  br_status_o;
    logic [63:0] ret_addr_o, hdl_addr_o, redir_target_o;
    logic        pend_o, redir_valid_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ebb_alert_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .alert_i(alert_i), .pc_i(pc_i),
        .user_mode_i(user_mode_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .mon_ctrl_o(mon_ctrl_o), .br_status_o(br_status_o),
        .ret_addr_o(ret_addr_o), .hdl_addr_o(hdl_addr_o), .pend_o(pend_o),
        .redir_valid_o(redir_valid_o), .redir_target_o(redir_target_o)
    );

    // {initial ctrl, expected ctrl after alert, expected pending}
    localparam logic [10:0] VEC [8] = '{
        {5'b00000, 5'b00000, 1'b0},
        {5'b01010, 5'b01010, 1'b0},
        {5'b00001, 5'b00001, 1'b1},
        {5'b00011, 5'b00101, 1'b1},
        {5'b01001, 5'b10001, 1'b1},
        {5'b01011, 5'b10101, 1'b1},
        {5'b11111, 5'b10101, 1'b1},
        {5'b10100, 5'b10100, 1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; alert_i = 1'b0; user_mode_i = 1'b0; wr_en_i = 1'b0;
        wr_sel_i = 2'd0; wr_data_i = '0; pc_i = '0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic alert_pulse();
        alert_i = 1'b1;
        @(negedge clk);
        alert_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R11: reset state
        check("R11 ctrl", 64'(mon_ctrl_o), 0);
        check("R11 status", 64'(br_status_o), 0);
        check("R11 pend", 64'(pend_o), 0);
        check("R11 ret", ret_addr_o, 0);

        // R1 R2 R3 R4: vector table, supervisor state keeps interrupt pending
        foreach (VEC[i]) begin
            do_reset();
            wr(2'd0, 64'(VEC[i][10:6]));
            alert_pulse();
            check("R2/R3 (R1) ctrl after alert", 64'(mon_ctrl_o), 64'(VEC[i][5:1]));
            check("R4 (R1) pending", 64'(pend_o), 64'(VEC[i][0]));
        end

        // R5 then R7 R9 R6: pending held in supervisor, then taken
        do_reset();
        wr(2'd1, 64'h3);
        wr(2'd3, 64'h1000_0000_0000_1237);
        wr(2'd0, 64'h1);
        alert_pulse();
        repeat (3) @(negedge clk);
        check("R5 still pending", 64'(pend_o), 1);
        check("R5 no redirect", 64'(redir_valid_o), 0);
        pc_i = 64'h0000_0000_0000_abcd;
        user_mode_i = 1'b1;
        @(negedge clk);
        user_mode_i = 1'b0;
        check("R7 redirect valid", 64'(redir_valid_o), 1);
        check("R9 target aligned", redir_target_o, 64'h1000_0000_0000_1234);
        check("R7 return addr", ret_addr_o, 64'habcd);
        check("R7 status", 64'(br_status_o), 64'h6);
        check("R6 pending cleared", 64'(pend_o), 0);
        @(negedge clk);
        check("R9 one cycle", 64'(redir_valid_o), 0);

        // R8: global enable clear -> drop, status and return kept
        do_reset();
        wr(2'd1, 64'h2);
        wr(2'd2, 64'h5550);
        wr(2'd0, 64'h1);
        alert_pulse();
        pc_i = 64'h7777; user_mode_i = 1'b1;
        @(negedge clk);
        user_mode_i = 1'b0;
        check("R8 no redirect", 64'(redir_valid_o), 0);
        check("R8 status kept", 64'(br_status_o), 64'h2);
        check("R8 return kept", ret_addr_o, 64'h5550);
        check("R6 pending cleared on drop", 64'(pend_o), 0);

        // R1: disabled alert in user state gives nothing
        do_reset();
        wr(2'd1, 64'h3);
        user_mode_i = 1'b1;
        alert_pulse();
        @(negedge clk);
        user_mode_i = 1'b0;
        check("R1 no pending", 64'(pend_o), 0);
        check("R1 no redirect", 64'(redir_valid_o), 0);

        // R10: alert collides with control write
        do_reset();
        wr(2'd0, 64'h03);
        alert_i = 1'b1;
        wr(2'd0, 64'h0b);
        alert_i = 1'b0;
        check("R10 ctrl merge", 64'(mon_ctrl_o), 64'h0d);

        // R10: take collides with status write
        do_reset();
        wr(2'd1, 64'h3);
        wr(2'd0, 64'h1);
        alert_pulse();
        user_mode_i = 1'b1;
        wr(2'd1, 64'h3);
        user_mode_i = 1'b0;
        check("R10 status merge", 64'(br_status_o), 64'h6);

        // R11: reset mid-run clears registers
        do_reset();
        check("R11 status after rerun", 64'(br_status_o), 0);
        check("R11 handler", hdl_addr_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule